// File: doc/BRIEF.md
# Sigma-Delta Pulse Density Modulator

This block converts a digital level into a one-bit pulse stream whose long-run fraction of ones equals the level divided by a run-time full-scale value. It is a first-order error-feedback loop. On each sample strobe a summing junction subtracts a fed-back level from the input code. The fed-back level is the full-scale value when the last output bit was high and zero when it was low. A signed accumulator adds this difference to its state, and a sign comparator on the updated accumulator picks the next output bit. An external RC low-pass filter turns the stream into an analog voltage.

The full-scale modulus is an input port, so it is not limited to powers of two. A modulus of 1000 gives a density of exactly code/1000. Pulses are spread as finely as the loop allows. At half scale the output toggles on every sample, which puts the ripple at half the sample rate instead of at the sample rate divided by the modulus, as in a single-burst PWM. At a 10,240 Hz strobe rate, for example, the half-scale output is a 5,120 Hz square wave. This lets the external filter use a time constant many times shorter.

Top module: `pdm_density_mod`

## Requirements
- R1: While reset is low, and after reset until the first sample strobe, the output is 0 and the accumulator holds 0.
- R2: The output and the accumulator change only on clock edges where the sample strobe is high. Changes to code or modulus while the strobe is low have no effect on the output.
- R3: The signed accumulator, which is two bits wider than the code, always stays within plus or minus (2^DW - 1), so it never wraps.
- R4: A code of 0 holds the output at 0 on every sample.
- R5: A code equal to or above the modulus is treated as equal to the modulus. Once the output is 1, it stays 1 on every following sample.
- R6: With a code equal to half an even modulus, the output after reset reads 1,0,1,0,... on consecutive samples.
- R7: After two settling samples following reset, any window of modulus-many consecutive samples contains exactly min(code, modulus) ones. This holds for moduli of 256, 1024, 1000 and other values that are not powers of two.
- R8: Each sample, the new output bit is 1 exactly when the updated accumulator is greater than zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_en_i | input | 1 | Sample strobe; one output decision per high cycle |
| code_i | input | DW | Requested level, unsigned |
| dmax_i | input | DW | Full-scale modulus (number of states), unsigned |
| pdm_o | output | 1 | Pulse density output bit |

## Verification
A corrupted accumulator or feedback choice shows up on the next strobed sample as a wrong bit. The half-scale alternation and the constant-0 and constant-1 patterns expose this within one or two samples. A smaller bias, such as an off-by-one in the summing junction or the clamp, leaves the pattern plausible. It only shows up as a ones count that differs from the code over one full window of modulus-many samples. The window counts are therefore taken exactly, including a modulus of 1000 and a code above the modulus.

// File: rtl/pdm_density_pkg.sv
`timescale 1ns/1ps
package pdm_density_pkg;

  // which level the switch returns to the summing junction
  typedef enum logic {
    FB_ZERO = 1'b0,
    FB_FULL = 1'b1
  } fb_sel_e;

  // accumulator headroom above the code width
  localparam int unsigned ACC_GUARD = 2;

  function automatic int unsigned acc_width(input int unsigned code_w);
    return code_w + ACC_GUARD;
  endfunction

endpackage

// File: rtl/pdm_code_limit.sv
`timescale 1ns/1ps
module pdm_code_limit #(
  parameter int unsigned DW = 11
) (
  input  logic [DW-1:0] code_i,
  input  logic [DW-1:0] dmax_i,
  output logic [DW-1:0] code_o
);

  always_comb begin
    if (code_i > dmax_i) begin
      code_o = dmax_i;
    end else begin
      code_o = code_i;
    end
  end

endmodule

// File: rtl/pdm_sum_junction.sv
`timescale 1ns/1ps
module pdm_sum_junction
  import pdm_density_pkg::*;
#(
  parameter int unsigned DW = 11,
  parameter int unsigned IW = DW + 2
) (
  input  logic [DW-1:0]        code_i,
  input  logic [DW-1:0]        dmax_i,
  input  fb_sel_e              fb_sel_i,
  input  logic signed [IW-1:0] acc_i,
  output logic signed [IW-1:0] acc_nx_o
);

  localparam int unsigned PAD = IW - DW;

  logic signed [IW-1:0] code_s;
  logic signed [IW-1:0] fb_s;
  logic signed [IW-1:0] err_s;

  assign code_s = $signed({{PAD{1'b0}}, code_i});

  always_comb begin
    if (fb_sel_i == FB_FULL) begin
      fb_s = $signed({{PAD{1'b0}}, dmax_i});
    end else begin
      fb_s = '0;
    end
  end

  assign err_s    = code_s - fb_s;
  assign acc_nx_o = acc_i + err_s;

endmodule

// File: rtl/pdm_acc_reg.sv
`timescale 1ns/1ps
module pdm_acc_reg #(
  parameter int unsigned IW = 13
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [IW-1:0] acc_nx_i,
  output logic signed [IW-1:0] acc_q_o,
  output logic                 bit_q_o
);

  logic signed [IW-1:0] acc_d;
  logic signed [IW-1:0] acc_q;
  logic                 bit_d;
  logic                 bit_q;

  // next state: comparator on the updated sum, hold when not strobed
  always_comb begin
    acc_d = acc_q;
    bit_d = bit_q;
    if (en_i) begin
      acc_d = acc_nx_i;
      bit_d = (acc_nx_i > 0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      bit_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      bit_q <= bit_d;
    end
  end

  assign acc_q_o = acc_q;
  assign bit_q_o = bit_q;

endmodule

// File: rtl/pdm_density_mod.sv
`timescale 1ns/1ps
module pdm_density_mod
  import pdm_density_pkg::*;
#(
  parameter int unsigned DW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_en_i,
  input  logic [DW-1:0] code_i,
  input  logic [DW-1:0] dmax_i,
  output logic          pdm_o
);

  localparam int unsigned IW = acc_width(DW);

  logic [DW-1:0]        code_lim;
  logic signed [IW-1:0] acc_q;
  logic signed [IW-1:0] acc_nx;
  logic                 pdm_q;
  fb_sel_e              fb_sel;

  assign fb_sel = pdm_q ? FB_FULL : FB_ZERO;

  pdm_code_limit #(.DW(DW)) u_limit (
    .code_i (code_i),
    .dmax_i (dmax_i),
    .code_o (code_lim)
  );

  pdm_sum_junction #(.DW(DW), .IW(IW)) u_junction (
    .code_i   (code_lim),
    .dmax_i   (dmax_i),
    .fb_sel_i (fb_sel),
    .acc_i    (acc_q),
    .acc_nx_o (acc_nx)
  );

  pdm_acc_reg #(.IW(IW)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (smp_en_i),
    .acc_nx_i (acc_nx),
    .acc_q_o  (acc_q),
    .bit_q_o  (pdm_q)
  );

  assign pdm_o = pdm_q;

endmodule

// File: rtl/pdm_density_chk.sv
`timescale 1ns/1ps
module pdm_density_chk #(
  parameter int unsigned DW = 11,
  parameter int unsigned IW = DW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 smp_en_i,
  input  logic [DW-1:0]        code_i,
  input  logic [DW-1:0]        dmax_i,
  input  logic signed [IW-1:0] acc_i,
  input  logic                 pdm_i
);

  localparam logic signed [IW-1:0] LIM_P = $signed({{(IW-DW){1'b0}}, {DW{1'b1}}});
  localparam logic signed [IW-1:0] LIM_N = -LIM_P;

  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
    end else if (smp_en_i) begin
      seen_q <= 1'b1;
    end
  end

  // R1: cleared state until the first strobe
  a_r1_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (acc_i == '0) && !pdm_i);

  // R2: nothing moves without the strobe
  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_en_i |=> $stable(pdm_i) && $stable(acc_i));

  // R3: accumulator stays inside its safe span
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i <= LIM_P) && (acc_i >= LIM_N));

  // R4: zero code keeps a low output low
  a_r4_zero_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_en_i && (code_i == '0) && !pdm_i |=> !pdm_i);

  // R5: full or clamped code keeps a high output high
  a_r5_full_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_en_i && (code_i >= dmax_i) && pdm_i |=> pdm_i);

endmodule

bind pdm_density_mod pdm_density_chk #(.DW(DW), .IW(IW)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .smp_en_i (smp_en_i),
  .code_i   (code_i),
  .dmax_i   (dmax_i),
  .acc_i    (acc_q),
  .pdm_i    (pdm_q)
);

// File: tb/pdm_density_mod_tb_top.sv
`timescale 1ns/1ps
module pdm_density_mod_tb_top;

  localparam int DW = 11;
  localparam int NV = 12;
  // stimulus: modulus, code (expected ones = min(code, modulus))
  localparam int V_DMAX [NV] = '{256, 256, 256, 256, 1024, 1024, 1024, 1000, 1000, 1000, 3, 5};
  localparam int V_CODE [NV] = '{0, 128, 256, 1, 512, 333, 1023, 500, 777, 1200, 1, 2};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic [DW-1:0] code;
  logic [DW-1:0] dmax;
  logic          pdm;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pdm_density_mod #(.DW(DW)) dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .smp_en_i (en),
    .code_i   (code),
    .dmax_i   (dmax),
    .pdm_o    (pdm)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    en    = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // entered at a falling edge; one strobed rising edge, back at a falling edge
  task automatic strobe();
    en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    en    = 1'b0;
    code  = '0;
    dmax  = 11'd256;
    @(negedge clk);
    // R1: state while reset is held
    check(pdm == 1'b0, "R1 in reset", int'(pdm), 0);
    do_reset();
    check(pdm == 1'b0, "R1 after release", int'(pdm), 0);

    // R7 / R4 / R5: exact ones count over one modulus window
    for (int v = 0; v < NV; v++) begin
      int ones;
      int exp;
      dmax = DW'(V_DMAX[v]);
      code = DW'(V_CODE[v]);
      exp  = (V_CODE[v] > V_DMAX[v]) ? V_DMAX[v] : V_CODE[v];
      do_reset();
      strobe();
      strobe();
      ones = 0;
      for (int s = 0; s < V_DMAX[v]; s++) begin
        strobe();
        ones += int'(pdm);
      end
      check(ones == exp, "R7 window count", ones, exp);
    end

    // R6: half scale alternates, power of two and not
    for (int k = 0; k < 2; k++) begin
      bit ok;
      dmax = (k == 0) ? 11'd256 : 11'd1000;
      code = (k == 0) ? 11'd128 : 11'd500;
      do_reset();
      ok = 1'b1;
      for (int s = 0; s < 16; s++) begin
        strobe();
        if (pdm != ((s % 2) == 0)) ok = 1'b0;
      end
      check(ok, "R6 alternation", int'(ok), 1);
    end

    // R4: zero code, long run, every sample low
    begin
      int highs;
      dmax = 11'd1000;
      code = '0;
      do_reset();
      highs = 0;
      for (int s = 0; s < 300; s++) begin
        strobe();
        highs += int'(pdm);
      end
      check(highs == 0, "R4 zero code highs", highs, 0);
    end

    // R5 / R8: clamped code is high from the first sample on
    begin
      int lows;
      dmax = 11'd700;
      code = 11'd2000;
      do_reset();
      lows = 0;
      for (int s = 0; s < 300; s++) begin
        strobe();
        lows += int'(!pdm);
      end
      check(lows == 0, "R5 clamp lows", lows, 0);
    end

    // R8: code 1 of 3 -> after reset sum 1>0 gives 1, then -1 gives 0, then 0 gives 0
    begin
      bit ok;
      dmax = 11'd3;
      code = 11'd1;
      do_reset();
      ok = 1'b1;
      for (int s = 0; s < 9; s++) begin
        strobe();
        if (pdm != ((s % 3) == 0)) ok = 1'b0;
      end
      check(ok, "R8 comparator pattern", int'(ok), 1);
    end

    // R2: inputs move with the strobe low, output holds
    begin
      logic held;
      bit   ok;
      dmax = 11'd256;
      code = 11'd128;
      do_reset();
      strobe();
      held = pdm;
      ok   = 1'b1;
      code = '0;
      dmax = 11'd5;
      for (int s = 0; s < 20; s++) begin
        @(negedge clk);
        code = DW'(s * 37);
        if (pdm != held) ok = 1'b0;
      end
      check(ok && held == 1'b1, "R2 idle hold", int'(pdm), int'(held));
      // resume at half scale: the next sample must be the 0 of the alternation
      dmax = 11'd256;
      code = 11'd128;
      strobe();
      check(pdm == 1'b0, "R2 state untouched", int'(pdm), 0);
    end

    // R1: reset mid-run clears the loop, alternation restarts with 1
    begin
      dmax = 11'd256;
      code = 11'd128;
      strobe();
      check(pdm == 1'b1, "R1 pre-reset phase", int'(pdm), 1);
      do_reset();
      check(pdm == 1'b0, "R1 mid-run reset", int'(pdm), 0);
      strobe();
      check(pdm == 1'b1, "R1 restart phase", int'(pdm), 1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule